// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps the bookkeeping for cache-line misses that are waiting on the next level of memory. A small fully associative table holds one entry per outstanding line. Each entry carries the line address, an address-space tag, the owning thread (or an "any thread" mark once requests from several threads share it), a no-allocate mark, an age stamp, a pending or in-service state, and a short list of requester IDs that are waiting on the same line.

A new cacheable request is compared against every live entry in one cycle. A match adds the requester to that entry's waiting list; no match opens the lowest-numbered free entry. Uncacheable requests skip the search and always open their own entry, which keeps the full request address instead of the line base. The block selects the next entry to send downstream (the oldest pending one, unless an entry whose waiting list has just filled was moved ahead), takes in-service notices and fill responses, and removes a thread's entries on a squash. Two stall outputs tell the cache to stop sending requests: one when the table is full, one when an entry's waiting list is full.

Top module: `miss_tracker`

## Requirements
- R1: A cacheable request matches a live cacheable entry only when both the line address (request address with its low BLK_LG bits cleared) and the address-space tag are equal; on a match `req_hit` is 1 and `req_slot` names that entry.
- R2: An uncacheable request (`req_uncache`=1) never matches an entry; it opens a new entry even when a live entry holds the same line.
- R3: When a request from a thread other than the entry's thread merges into it, the entry is marked "any thread" and a later squash of either thread leaves it in the table.
- R4: A request with `req_noalloc`=0 that merges into an entry opened with `req_noalloc`=1 clears that entry's no-allocate mark, as seen on `issue_nalloc` when the entry is the issue choice.
- R5: When a merge brings an entry's waiting list to N_TGT requesters, `stall_tgt` rises on the next cycle, the entry becomes the issue choice ahead of older pending entries, and further merges into it are refused (`req_ok`=0).
- R6: Each newly opened entry receives the current global age stamp and the stamp then advances; among pending entries without priority, `issue_slot` names the one with the oldest stamp.
- R7: Opening the last free entry raises `stall_full` on the next cycle; while the table is full and no entry is freed in the same cycle, a request that does not match is refused.
- R8: A fill response (`rsp_fill`=1) with `rsp_left` > 0 returns the entry to pending with a fresh age stamp, drops the served requesters from the front of its list, and releases `stall_tgt` if this entry caused it.
- R9: A fill response with `rsp_left`=0, or any response with `rsp_fill`=0, frees the entry; `stall_full` falls only if the table is no longer full after the cycle's updates.
- R10: A squash removes every entry whose thread equals `sq_thread` and is not marked "any thread", releases `stall_tgt` if its entry belongs to that thread, and ignores all other request, response and in-service inputs in that cycle.
- R11: A new entry always takes the lowest-numbered free slot; a response and a request in the same cycle are applied response first, so a slot freed by the response is reused at once.
- R12: `rsp_tid` and `rsp_cnt` show the first waiting requester ID and the list length of the entry named by `rsp_slot`.
- R13: `svc_valid` moves a pending entry to in service so it is no longer an issue choice; `issue_req` is 1 exactly when some entry is pending; after reset both stalls and `issue_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup/allocate request strobe |
| req_addr | input | ADDR_W | Request byte address |
| req_asid | input | ASID_W | Request address-space tag |
| req_thread | input | THR_W | Requesting thread |
| req_uncache | input | 1 | Request is uncacheable |
| req_noalloc | input | 1 | Request must not allocate in the cache |
| req_tid | input | TID_W | Requester ID to record |
| req_hit | output | 1 | Request matches a live entry |
| req_ok | output | 1 | Request is taken this cycle |
| req_slot | output | IDX_W | Entry merged into or opened |
| rsp_valid | input | 1 | Response strobe for an in-service entry |
| rsp_slot | input | IDX_W | Entry the response belongs to |
| rsp_fill | input | 1 | Response is a cacheable line fill |
| rsp_left | input | CNT_W | Requesters still unserved after the fill |
| rsp_tid | output | TID_W | First waiting requester of entry `rsp_slot` |
| rsp_cnt | output | CNT_W | Waiting-list length of entry `rsp_slot` |
| svc_valid | input | 1 | Mark-in-service strobe |
| svc_slot | input | IDX_W | Entry sent downstream |
| sq_valid | input | 1 | Squash strobe |
| sq_thread | input | THR_W | Thread to squash |
| issue_req | output | 1 | Some entry is pending |
| issue_slot | output | IDX_W | Entry to send next |
| issue_nalloc | output | 1 | No-allocate mark of the issue choice |
| stall_full | output | 1 | No free entry |
| stall_tgt | output | 1 | An entry's waiting list is full |

## Verification
The hardest state to reach is a full waiting list on an entry that is younger than other pending entries, because only then is the priority move visible on `issue_slot`; the stimulus fills the table, squashes one thread to free a slot, and stacks merges onto the newest entry. A second awkward case is a response and an allocation landing on the same edge while the table is full, which the directed part lines up explicitly. A seeded random phase over a small pool of lines then mixes requests, in-service notices and freeing responses, checking hits, slot choice and the full stall against a bench model.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_PEND = 2'd1,
    ST_BUSY = 2'd2
  } ent_st_t;

  // Line base: clear the low lg address bits.
  function automatic logic [31:0] line_base(input logic [31:0] a, input int lg);
    return a & ~((32'd1 << lg) - 32'd1);
  endfunction

  // Wrap-safe age compare over a w-bit stamp: 1 when a is older than b.
  function automatic logic stamp_before(input logic [31:0] a, input logic [31:0] b,
                                        input int w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

endpackage

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int N_ENT  = 4,
  parameter int ADDR_W = 16,
  parameter int ASID_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic [N_ENT-1:0]             live,
  input  logic [N_ENT-1:0]             cand,
  input  logic [N_ENT-1:0][ADDR_W-1:0] blk,
  input  logic [N_ENT-1:0][ASID_W-1:0] asid,
  input  logic                         look,
  input  logic [ADDR_W-1:0]            key_blk,
  input  logic [ASID_W-1:0]            key_asid,
  output logic [N_ENT-1:0]             match_vec,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx,
  output logic                         free_any,
  output logic [IDX_W-1:0]             free_idx
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match_vec[g] = look && cand[g] && (blk[g] == key_blk) && (asid[g] == key_asid);
  end

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!live[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int N_ENT = 4,
  parameter int ORD_W = 8,
  parameter int IDX_W = 2
) (
  input  logic [N_ENT-1:0]            pend,
  input  logic [N_ENT-1:0]            front,
  input  logic [N_ENT-1:0][ORD_W-1:0] ord,
  output logic                        any,
  output logic [IDX_W-1:0]            idx
);
  import mshr_pkg::*;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (pend[i]) begin
        if (!any) begin
          any = 1'b1;
          idx = IDX_W'(i);
        end else if (front[i] && !front[idx]) begin
          idx = IDX_W'(i);
        end else if ((front[i] == front[idx]) &&
                     stamp_before(32'(ord[i]), 32'(ord[idx]), ORD_W)) begin
          idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int N_ENT  = 4,
  parameter int N_TGT  = 4,
  parameter int ADDR_W = 16,
  parameter int BLK_LG = 4,
  parameter int ASID_W = 2,
  parameter int THR_W  = 2,
  parameter int TID_W  = 4,
  parameter int ORD_W  = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int CNT_W = $clog2(N_TGT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [THR_W-1:0]  req_thread,
  input  logic              req_uncache,
  input  logic              req_noalloc,
  input  logic [TID_W-1:0]  req_tid,
  output logic              req_hit,
  output logic              req_ok,
  output logic [IDX_W-1:0]  req_slot,
  input  logic              rsp_valid,
  input  logic [IDX_W-1:0]  rsp_slot,
  input  logic              rsp_fill,
  input  logic [CNT_W-1:0]  rsp_left,
  output logic [TID_W-1:0]  rsp_tid,
  output logic [CNT_W-1:0]  rsp_cnt,
  input  logic              svc_valid,
  input  logic [IDX_W-1:0]  svc_slot,
  input  logic              sq_valid,
  input  logic [THR_W-1:0]  sq_thread,
  output logic              issue_req,
  output logic [IDX_W-1:0]  issue_slot,
  output logic              issue_nalloc,
  output logic              stall_full,
  output logic              stall_tgt
);
  import mshr_pkg::*;

  // Entry state
  ent_st_t                              e_st [N_ENT];
  logic [N_ENT-1:0][ADDR_W-1:0]         e_blk;
  logic [N_ENT-1:0][ASID_W-1:0]         e_asid;
  logic [N_ENT-1:0][THR_W-1:0]          e_thr;
  logic [N_ENT-1:0]                     e_any, e_nalloc, e_unc, e_front;
  logic [N_ENT-1:0][ORD_W-1:0]          e_ord;
  logic [N_ENT-1:0][CNT_W-1:0]          e_cnt;
  logic [N_ENT-1:0][N_TGT-1:0][TID_W-1:0] e_tgt;
  logic [ORD_W-1:0]                     ord_ctr;
  logic [IDX_W-1:0]                     tgt_owner;

  // Named events for the checker
  logic                         rsp_fire, rsp_keep, svc_fire, alloc_new, merge_fire, cap_hit;
  logic [CNT_W-1:0]             left_c;
  logic [N_ENT-1:0]             live_mid, cand, vld_vec, vld_next, pend_vec, sq_kill, match_vec;
  logic [N_ENT-1:0][CNT_W-1:0]  cnt_mid;
  logic [N_ENT-1:0][N_TGT-1:0][TID_W-1:0] tgt_mid;
  logic                         hit, free_any, look, owner_full;
  logic [IDX_W-1:0]             hit_idx, free_idx;
  logic [ADDR_W-1:0]            key_blk;

  // Response is applied first
  assign rsp_fire = rsp_valid && !sq_valid && (e_st[rsp_slot] == ST_BUSY);
  assign left_c   = (rsp_left > e_cnt[rsp_slot]) ? e_cnt[rsp_slot] : rsp_left;
  assign rsp_keep = rsp_fire && rsp_fill && (left_c != '0);
  assign svc_fire = svc_valid && !sq_valid && (e_st[svc_slot] == ST_PEND);

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      vld_vec[i]  = (e_st[i] != ST_FREE);
      pend_vec[i] = (e_st[i] == ST_PEND);
      live_mid[i] = vld_vec[i] && !(rsp_fire && !rsp_keep && (rsp_slot == IDX_W'(i)));
      cand[i]     = live_mid[i] && !e_unc[i];
      sq_kill[i]  = sq_valid && vld_vec[i] && !e_any[i] && (e_thr[i] == sq_thread);
      cnt_mid[i]  = e_cnt[i];
      tgt_mid[i]  = e_tgt[i];
      if (rsp_keep && (rsp_slot == IDX_W'(i))) begin
        cnt_mid[i] = left_c;
        for (int j = 0; j < N_TGT; j++) begin
          tgt_mid[i][j] = '0;
          if (j + int'(e_cnt[i]) - int'(left_c) < N_TGT)
            tgt_mid[i][j] = e_tgt[i][j + int'(e_cnt[i]) - int'(left_c)];
        end
      end
    end
  end

  assign look    = req_valid && !sq_valid && !req_uncache;
  assign key_blk = ADDR_W'(line_base(32'(req_addr), BLK_LG));

  mshr_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_match (
    .live(live_mid), .cand(cand), .blk(e_blk), .asid(e_asid), .look(look),
    .key_blk(key_blk), .key_asid(req_asid), .match_vec(match_vec), .hit(hit),
    .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx));

  assign alloc_new  = req_valid && !sq_valid && !hit && free_any;
  assign merge_fire = hit && (cnt_mid[hit_idx] < CNT_W'(N_TGT));
  assign cap_hit    = merge_fire && (cnt_mid[hit_idx] + CNT_W'(1) == CNT_W'(N_TGT));
  assign req_hit    = hit;
  assign req_ok     = alloc_new || merge_fire;
  assign req_slot   = hit ? hit_idx : free_idx;

  always_comb begin
    for (int i = 0; i < N_ENT; i++)
      vld_next[i] = sq_valid ? (vld_vec[i] && !sq_kill[i])
                             : (live_mid[i] || (alloc_new && (free_idx == IDX_W'(i))));
  end

  mshr_pick #(.N_ENT(N_ENT), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_pick (
    .pend(pend_vec), .front(e_front), .ord(e_ord), .any(issue_req), .idx(issue_slot));

  assign issue_nalloc = e_nalloc[issue_slot];
  assign rsp_tid      = e_tgt[rsp_slot][0];
  assign rsp_cnt      = e_cnt[rsp_slot];
  assign owner_full   = vld_vec[tgt_owner] && (e_cnt[tgt_owner] == CNT_W'(N_TGT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) e_st[i] <= ST_FREE;
      e_blk <= '0; e_asid <= '0; e_thr <= '0; e_any <= '0; e_nalloc <= '0;
      e_unc <= '0; e_front <= '0; e_ord <= '0; e_cnt <= '0; e_tgt <= '0;
      ord_ctr <= '0; tgt_owner <= '0; stall_full <= 1'b0; stall_tgt <= 1'b0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (sq_kill[i]) begin
          e_st[i]    <= ST_FREE;
          e_front[i] <= 1'b0;
        end
        if (!sq_valid) begin
          e_cnt[i] <= cnt_mid[i];
          e_tgt[i] <= tgt_mid[i];
          if (rsp_fire && (rsp_slot == IDX_W'(i))) begin
            e_st[i] <= rsp_keep ? ST_PEND : ST_FREE;
            if (rsp_keep) e_ord[i] <= ord_ctr;
          end
          if (svc_fire && (svc_slot == IDX_W'(i))) begin
            e_st[i]    <= ST_BUSY;
            e_front[i] <= 1'b0;
          end
        end
      end
      if (alloc_new) begin
        e_st[free_idx]     <= ST_PEND;
        e_blk[free_idx]    <= req_uncache ? req_addr : key_blk;
        e_asid[free_idx]   <= req_asid;
        e_thr[free_idx]    <= req_thread;
        e_any[free_idx]    <= 1'b0;
        e_nalloc[free_idx] <= req_noalloc;
        e_unc[free_idx]    <= req_uncache;
        e_front[free_idx]  <= 1'b0;
        e_ord[free_idx]    <= ord_ctr + ORD_W'(rsp_keep);
        e_cnt[free_idx]    <= CNT_W'(1);
        e_tgt[free_idx]    <= '0;
        e_tgt[free_idx][0] <= req_tid;
      end
      if (merge_fire) begin
        if (e_thr[hit_idx] != req_thread) e_any[hit_idx] <= 1'b1;
        if (!req_noalloc) e_nalloc[hit_idx] <= 1'b0;
        e_tgt[hit_idx][cnt_mid[hit_idx]] <= req_tid;
        e_cnt[hit_idx] <= cnt_mid[hit_idx] + CNT_W'(1);
        if (cap_hit) e_front[hit_idx] <= 1'b1;
      end
      ord_ctr    <= ord_ctr + ORD_W'(rsp_keep) + ORD_W'(alloc_new);
      stall_full <= &vld_next;
      if (sq_valid) begin
        if (!e_any[tgt_owner] && (e_thr[tgt_owner] == sq_thread)) stall_tgt <= 1'b0;
      end else if (cap_hit) begin
        stall_tgt <= 1'b1;
        tgt_owner <= hit_idx;
      end else if (rsp_fire && (rsp_slot == tgt_owner)) begin
        stall_tgt <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mshr_checker.sv
module mshr_checker #(
  parameter int N_ENT = 4,
  parameter int ORD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_full,
  input logic             stall_tgt,
  input logic             issue_req,
  input logic [N_ENT-1:0] pend_vec,
  input logic [N_ENT-1:0] vld_vec,
  input logic [N_ENT-1:0] match_vec,
  input logic             req_valid,
  input logic             req_uncache,
  input logic             req_hit,
  input logic             req_ok,
  input logic             rsp_valid,
  input logic             alloc_new,
  input logic             rsp_keep,
  input logic             owner_full,
  input logic [ORD_W-1:0] ord_ctr
);
  // R7
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_full == ($countones(vld_vec) == N_ENT));
  // R7
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_full && !rsp_valid) |-> !(req_ok && !req_hit));
  // R2
  unc_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_uncache) |-> (match_vec == '0));
  // R1
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  // R13
  issue_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_req == (pend_vec != '0));
  // R6
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ord_ctr == $past(ord_ctr) + {{(ORD_W-1){1'b0}}, $past(alloc_new)}
                                        + {{(ORD_W-1){1'b0}}, $past(rsp_keep)});
  // R5
  tgt_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_tgt |-> owner_full);
endmodule

bind miss_tracker mshr_checker #(.N_ENT(N_ENT), .ORD_W(ORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_full(stall_full), .stall_tgt(stall_tgt),
  .issue_req(issue_req), .pend_vec(pend_vec), .vld_vec(vld_vec), .match_vec(match_vec),
  .req_valid(req_valid), .req_uncache(req_uncache), .req_hit(req_hit), .req_ok(req_ok),
  .rsp_valid(rsp_valid), .alloc_new(alloc_new), .rsp_keep(rsp_keep),
  .owner_full(owner_full), .ord_ctr(ord_ctr));

// File: tb/tb_miss_tracker.sv
module tb_miss_tracker;
  localparam int N_ENT = 4, N_TGT = 4, BLK = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_uncache = 0, req_noalloc = 0;
  logic [15:0] req_addr = '0;
  logic [1:0] req_asid = '0, req_thread = '0, rsp_slot = '0, svc_slot = '0, sq_thread = '0;
  logic [3:0] req_tid = '0;
  logic rsp_valid = 0, rsp_fill = 0, svc_valid = 0, sq_valid = 0;
  logic [2:0] rsp_left = '0;
  logic req_hit, req_ok, issue_req, issue_nalloc, stall_full, stall_tgt;
  logic [1:0] req_slot, issue_slot;
  logic [3:0] rsp_tid;
  logic [2:0] rsp_cnt;

  miss_tracker dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic c_hit, c_ok;
  logic [1:0] c_slot;
  logic [3:0] c_tid;
  logic [2:0] c_cnt;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] line_of(input logic [15:0] a);
    return a - (a % BLK);
  endfunction

  // All tasks start and end at a falling edge.
  task automatic do_req(input logic [15:0] a, input logic [1:0] asid, input logic [1:0] thr,
                        input logic unc, input logic nal, input logic [3:0] tid);
    req_valid = 1; req_addr = a; req_asid = asid; req_thread = thr;
    req_uncache = unc; req_noalloc = nal; req_tid = tid;
    #2; c_hit = req_hit; c_ok = req_ok; c_slot = req_slot;
    @(negedge clk); req_valid = 0; req_uncache = 0; req_noalloc = 0;
  endtask

  task automatic do_rsp(input logic [1:0] s, input logic fill, input logic [2:0] left);
    rsp_valid = 1; rsp_slot = s; rsp_fill = fill; rsp_left = left;
    #2; c_tid = rsp_tid; c_cnt = rsp_cnt;
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic do_svc(input logic [1:0] s);
    svc_valid = 1; svc_slot = s;
    @(negedge clk); svc_valid = 0;
  endtask

  task automatic do_sq(input logic [1:0] t);
    sq_valid = 1; sq_thread = t;
    @(negedge clk); sq_valid = 0;
  endtask

  // Bench model for the random phase
  logic m_vld [N_ENT];
  logic m_busy [N_ENT];
  logic [15:0] m_blk [N_ENT];
  int m_cnt [N_ENT];

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    check("R13 reset issue_req", issue_req, 0);
    check("R7 reset stall_full", stall_full, 0);
    check("R5 reset stall_tgt", stall_tgt, 0);

    do_req(16'h100, 0, 0, 0, 0, 4'd1);
    check("R11 first slot", {c_hit, c_ok, c_slot}, {1'b0, 1'b1, 2'd0});
    do_req(16'h10C, 0, 1, 0, 0, 4'd2);
    check("R1 same line merges", {c_hit, c_slot}, {1'b1, 2'd0});
    do_req(16'h104, 1, 1, 0, 0, 4'd3);
    check("R1 other asid misses", {c_hit, c_slot}, {1'b0, 2'd1});
    do_req(16'h100, 0, 0, 1, 0, 4'd4);
    check("R2 uncacheable new entry", {c_hit, c_ok, c_slot}, {1'b0, 1'b1, 2'd2});
    check("R6 oldest issue", issue_slot, 0);
    do_req(16'h200, 0, 0, 0, 1, 4'd5);
    check("R7 last slot", c_slot, 3);
    check("R7 stall_full set", stall_full, 1);
    do_req(16'h300, 0, 0, 0, 0, 4'd6);
    check("R7 refused when full", {c_hit, c_ok}, {1'b0, 1'b0});
    do_req(16'h208, 0, 0, 0, 0, 4'd6);
    check("R4 allocating merge", {c_hit, c_slot}, {1'b1, 2'd3});

    do_sq(1);
    check("R10 squash frees", stall_full, 0);
    do_req(16'h104, 1, 0, 0, 0, 4'd9);
    check("R10 squashed entry gone", {c_hit, c_ok, c_slot}, {1'b0, 1'b1, 2'd1});
    check("R7 full again", stall_full, 1);
    do_req(16'h100, 0, 2, 0, 0, 4'd10);
    check("R3 any-thread entry kept", {c_hit, c_slot}, {1'b1, 2'd0});

    do_req(16'h200, 0, 0, 0, 0, 4'd7);
    check("R5 merge 3", c_ok, 1);
    check("R5 not yet capped", stall_tgt, 0);
    do_req(16'h204, 0, 0, 0, 0, 4'd8);
    check("R5 cap stall", stall_tgt, 1);
    check("R5 promoted issue", issue_slot, 3);
    check("R4 noalloc cleared", issue_nalloc, 0);
    do_req(16'h20C, 0, 0, 0, 0, 4'd11);
    check("R5 merge refused", {c_hit, c_ok}, {1'b1, 1'b0});

    do_svc(3);
    check("R13 in-service leaves issue", issue_slot, 0);
    do_rsp(3, 1, 3'd2);
    check("R12 head before fill", {c_tid, c_cnt}, {4'd5, 3'd4});
    check("R8 stall_tgt released", stall_tgt, 0);
    do_svc(0);
    check("R6 next oldest", issue_slot, 2);
    do_svc(2);
    check("R6 then", issue_slot, 1);
    do_svc(1);
    check("R8 repended goes last", issue_slot, 3);
    do_svc(3);
    check("R13 none pending", issue_req, 0);
    do_rsp(3, 1, 3'd0);
    check("R12 head after partial fill", {c_tid, c_cnt}, {4'd7, 3'd2});
    check("R9 full released", stall_full, 0);

    do_req(16'h600, 0, 0, 0, 0, 4'd12);
    check("R7 refilled", {c_slot, stall_full}, {2'd3, 1'b1});
    rsp_valid = 1; rsp_slot = 0; rsp_fill = 1; rsp_left = 0;
    do_req(16'h700, 0, 0, 0, 0, 4'd13);
    rsp_valid = 0;
    check("R11 response first reuse", {c_ok, c_slot}, {1'b1, 2'd0});
    check("R9 still full", stall_full, 1);
    do_rsp(2, 0, 3'd0);
    check("R9 non-fill frees", stall_full, 0);

    for (int k = 0; k < 4; k++) do_req(16'h800, 0, 3, 0, 0, 4'(k));
    check("R5 cap on slot2", {c_slot, stall_tgt}, {2'd2, 1'b1});
    do_sq(3);
    check("R10 squash releases tgt", stall_tgt, 0);
    do_req(16'h800, 0, 0, 0, 0, 4'd1);
    check("R10 slot freed", {c_hit, c_slot}, {1'b0, 2'd2});

    // Random phase
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    for (int i = 0; i < N_ENT; i++) begin
      m_vld[i] = 0; m_busy[i] = 0; m_blk[i] = '0; m_cnt[i] = 0;
    end
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 3;
      if (op == 0) begin
        logic [15:0] a;
        int ms, fs;
        logic e_hit, e_ok;
        a = 16'((($urandom % 6) * BLK) + ($urandom % BLK));
        ms = -1; fs = -1;
        for (int i = N_ENT - 1; i >= 0; i--) begin
          if (m_vld[i] && m_blk[i] == line_of(a)) ms = i;
          if (!m_vld[i]) fs = i;
        end
        e_hit = (ms >= 0);
        e_ok  = e_hit ? (m_cnt[ms] < N_TGT) : (fs >= 0);
        do_req(a, 0, 0, 0, 0, 4'(it));
        check("R1 random hit", {c_hit, c_ok}, {e_hit, e_ok});
        if (e_ok) check("R11 random slot", c_slot, e_hit ? ms : fs);
        if (e_ok && e_hit) m_cnt[ms]++;
        if (e_ok && !e_hit) begin
          m_vld[fs] = 1; m_busy[fs] = 0; m_blk[fs] = line_of(a); m_cnt[fs] = 1;
        end
      end else if (op == 1) begin
        if (issue_req) begin
          m_busy[issue_slot] = 1;
          do_svc(issue_slot);
        end else @(negedge clk);
      end else begin
        int st, pick;
        st = $urandom % N_ENT; pick = -1;
        for (int j = 0; j < N_ENT; j++)
          if (pick < 0 && m_busy[(st + j) % N_ENT]) pick = (st + j) % N_ENT;
        if (pick >= 0) begin
          do_rsp(2'(pick), 1, 3'd0);
          m_vld[pick] = 0; m_busy[pick] = 0; m_cnt[pick] = 0;
        end else @(negedge clk);
      end
      check("R9 random full flag", stall_full,
            (m_vld[0] && m_vld[1] && m_vld[2] && m_vld[3]));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule